// File: doc/BRIEF.md
# Input Capture Unit with Glitch Filter

This block timestamps transitions on an external capture pin. The pin is first passed through a flop synchronizer. An optional glitch filter can follow it; the filter lets a new level through only once the pin has held that level for several clock samples in a row. An edge detector then compares the clean level with its value one cycle earlier and reacts only to the polarity that software selected. On a qualifying edge, the block latches the value of an external free-running 16-bit counter into a capture register and sets a sticky capture flag. The flag, gated by an interrupt enable, drives an interrupt request.

The capture register can also serve as the timer's period (TOP) value. While the `cap_block` input says it is doing so, the pin is ignored and no capture happens. In that state the register accepts writes from the bus port, so software can load the period. The counter and the bus decode sit outside this block.

Top module: `edge_stamp_capture`

## Requirements
- R1: With `filt_en`=1 the clean level changes only after four consecutive synchronized samples agree. A pin pulse of one, two or three clock cycles produces no capture. A pulse of four cycles produces one capture.
- R2: With `filt_en`=0, a pin change applied before clock edge E0 is captured at edge E3, and the register then holds the counter value present at E3. With `filt_en`=1 the capture moves four edges later, to E7.
- R3: `edge_rise`=1 selects low-to-high pin transitions and `edge_rise`=0 selects high-to-low transitions. A transition of the other polarity never captures.
- R4: A capture copies `count_val` into `cap_value` and sets `cap_flag` to 1. The flag stays set until it is cleared.
- R5: `irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R6: While `cap_block`=1, no pin edge changes `cap_value` or sets `cap_flag`.
- R7: A one-cycle pulse on `flag_clr` (write-one-to-clear) clears `cap_flag` at the next clock edge.
- R8: If a capture and a `flag_clr` pulse fall on the same edge, the capture wins. `cap_flag` ends at 1 and `cap_value` takes the new count.
- R9: `wr_en`=1 loads `wr_data` into `cap_value` at the next edge only while `cap_block`=1. While `cap_block`=0 the write is ignored.
- R10: After synchronous active-low reset, `cap_value`=0, `cap_flag`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous capture pin |
| count_val | input | 16 | Free-running counter value to be stamped |
| filt_en | input | 1 | Enables the four-sample glitch filter |
| edge_rise | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| cap_block | input | 1 | Capture register in use as TOP; capture disabled |
| flag_clr | input | 1 | Write-one strobe that clears the capture flag |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Bus write strobe for the capture register |
| wr_data | input | 16 | Bus write data |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clear strobe that lands on the very edge where a capture commits. The pin and filter pipeline hides that edge several cycles behind the stimulus. The bench counts those cycles from the pin change and raises `flag_clr` on the third edge, then confirms that the flag survives and that the new count is latched. A second hard case is the filter boundary, where a pulse one cycle shorter than the threshold must vanish. The bench sweeps pulse widths from one to four cycles, with and without the filter.

// File: rtl/cap_pkg.sv
// Package: shared definitions for the input capture unit.
// Assumes: nothing beyond a SystemVerilog 2017 compiler.
package cap_pkg;
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    // Returns 1 when every bit of a sample window holds the same value.
    function automatic logic window_agrees(input logic [7:0] win, input int len);
        logic all_hi;
        logic all_lo;
        all_hi = 1'b1;
        all_lo = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i < len) begin
                all_hi &= win[i];
                all_lo &= ~win[i];
            end
        end
        return all_hi | all_lo;
    endfunction
endpackage

// File: rtl/cap_sync.sv
// Module: flop-chain synchronizer for the asynchronous capture pin.
// Assumes: STAGES >= 2; the reset level of the chain is 0, so the pin
// should idle low while reset is applied.
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift the pin one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= d_async;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
// Module: glitch filter. When enabled, the output takes a new level only
// after DEPTH consecutive stored samples agree. When disabled, the output
// follows the input with one register of delay, so enabling the filter
// adds exactly DEPTH cycles of latency.
// Assumes: 1 <= DEPTH <= 8.
module cap_filter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    import cap_pkg::*;

    logic [DEPTH-1:0] hist;
    logic [7:0]       win;

    // Purpose: zero-extend the history into the fixed-width window.
    always_comb begin
        win = '0;
        win[DEPTH-1:0] = hist;
    end

    generate
        if (DEPTH == 1) begin : g_short
            // Purpose: hold the single most recent sample.
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= din;
            end
        end else begin : g_long
            // Purpose: shift the newest sample into the history window.
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[DEPTH-2:0], din};
            end
        end
    endgenerate

    // Purpose: update the clean level, either directly or on agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (!en) begin
            dout <= din;
        end else if (window_agrees(win, DEPTH)) begin
            dout <= hist[0];
        end
    end
endmodule

// File: rtl/cap_edge.sv
// Module: edge detector. Compares the clean level with its value one
// cycle earlier and pulses hit for one cycle on the selected polarity.
// Assumes: level is glitch-free and synchronous to clk.
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic hit
);
    import cap_pkg::*;

    logic      prev;
    edge_sel_e sel;

    // Purpose: remember the level seen at the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    // Purpose: pick the transition polarity that counts as an event.
    always_comb begin
        sel = edge_sel_e'(rise_sel);
        if (sel == EDGE_RISE) hit = level & ~prev;
        else                  hit = ~level & prev;
    end
endmodule

// File: rtl/cap_store.sv
// Module: capture register and sticky flag. A capture beats a same-cycle
// flag clear; bus writes land only while capture is blocked.
// Assumes: hit is a single-cycle pulse.
module cap_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         block,
    input  logic [W-1:0] stamp,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         flag
);
    logic take;

    // Purpose: a capture commits only while the register is not TOP.
    assign take = hit & ~block;

    // Purpose: load the register from a capture or from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)          value <= '0;
        else if (take)       value <= stamp;
        else if (wr && block) value <= wdata;
    end

    // Purpose: set the flag on capture, clear it on strobe, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (take) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/edge_stamp_capture.sv
// Module: input capture unit top. Chains synchronizer, glitch filter,
// edge detector and capture store, and forms the interrupt request.
// Assumes: count_val is synchronous to clk; the pin idles low in reset.
module edge_stamp_capture #(
    parameter int CNT_W      = 16,
    parameter int SYNC_DEPTH = 2,
    parameter int FILT_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] count_val,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             cap_block,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             irq
);
    logic sync_pin;
    logic clean_pin;
    logic edge_hit;

    cap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(sync_pin)
    );

    cap_filter #(.DEPTH(FILT_DEPTH)) u_filt (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .din(sync_pin), .dout(clean_pin)
    );

    cap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(clean_pin), .rise_sel(edge_rise), .hit(edge_hit)
    );

    cap_store #(.W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .hit(edge_hit), .block(cap_block),
        .stamp(count_val), .clr(flag_clr), .wr(wr_en), .wdata(wr_data),
        .value(cap_value), .flag(cap_flag)
    );

    // Purpose: raise the interrupt while the flag is set and enabled.
    assign irq = cap_flag & irq_en;
endmodule

// File: rtl/edge_stamp_capture_chk.sv
// Module: property checker for the input capture unit, bound to the top.
// Assumes: observes the top's ports plus the clean level and edge pulse.
module edge_stamp_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_rise,
    input logic             cap_block,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             wr_en,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             irq,
    input logic             clean_pin,
    input logic             edge_hit
);
    // R3: an event pulse only ever shows the selected polarity's new level.
    a_r3_edge_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (clean_pin == edge_rise));

    // R4: an unblocked event leaves the flag set on the following cycle.
    a_r4_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !cap_block) |=> cap_flag);

    // R6: while blocked and not written, the register holds its value.
    a_r6_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_block && !wr_en) |=> $stable(cap_value));

    // R9: with capture open, only an event can change the register.
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_block && !edge_hit) |=> $stable(cap_value));

    // R7: a clear without a competing capture drops the flag.
    a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(edge_hit && !cap_block)) |=> !cap_flag);

    // R5: the interrupt never asserts without both flag and enable.
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_flag && irq_en));
endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .edge_rise(edge_rise), .cap_block(cap_block),
    .flag_clr(flag_clr), .irq_en(irq_en), .wr_en(wr_en), .cap_value(cap_value),
    .cap_flag(cap_flag), .irq(irq), .clean_pin(clean_pin), .edge_hit(edge_hit)
);

// File: tb/edge_stamp_capture_test.sv
module edge_stamp_capture_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] count_val = 16'h1000;
    logic        filt_en = 1'b0;
    logic        edge_rise = 1'b1;
    logic        cap_block = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cap_value;
    logic        cap_flag;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] exp_val;

    edge_stamp_capture uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_val(count_val),
        .filt_en(filt_en), .edge_rise(edge_rise), .cap_block(cap_block),
        .flag_clr(flag_clr), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
        .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running stamp source, advanced away from the active edge.
    initial forever begin
        @(negedge clk);
        count_val = count_val + 16'd1;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        wait_neg(1);
        flag_clr = 1'b0;
    endtask

    // Settle the pin at a level, then clear the flag and record the register.
    task automatic settle(input logic lvl);
        pin_in = lvl;
        wait_neg(14);
        clear_flag();
        exp_val = cap_value;
    endtask

    // Apply one transition and check latency, flag and stamp.
    task automatic one_edge(input logic filt, input logic sel, input logic dir);
        int lat;
        logic [15:0] c0;
        logic hit;
        filt_en = filt;
        edge_rise = sel;
        settle(~dir);
        lat = filt ? 7 : 3;
        hit = (dir == sel);
        pin_in = dir;
        #1 c0 = count_val;
        wait_neg(lat);
        check(cap_flag == 1'b0, "R2 flag before capture edge", cap_flag, 0);
        wait_neg(1);
        check(cap_flag == hit, "R3 edge select flag", cap_flag, hit);
        if (hit) exp_val = c0 + 16'(lat);
        check(cap_value == exp_val, "R4 R2 captured stamp", cap_value, exp_val);
    endtask

    // Pulse the pin high for w cycles and check whether a capture results.
    task automatic pulse(input logic filt, input int w);
        logic [15:0] c0;
        logic hit;
        filt_en = filt;
        edge_rise = 1'b1;
        settle(1'b0);
        hit = !filt || (w >= 4);
        pin_in = 1'b1;
        #1 c0 = count_val;
        wait_neg(w);
        pin_in = 1'b0;
        wait_neg(14);
        check(cap_flag == hit, "R1 pulse width filter", cap_flag, hit);
        if (hit) exp_val = c0 + (filt ? 16'd7 : 16'd3);
        check(cap_value == exp_val, "R1 pulse stamp", cap_value, exp_val);
    endtask

    initial begin
        logic [15:0] c0;
        wait_neg(3);
        check(cap_value == 16'h0 && cap_flag == 1'b0 && irq == 1'b0, "R10 reset state",
              {cap_value, 7'b0, cap_flag, 7'b0, irq}, 0);
        rst_n = 1'b1;
        wait_neg(1);

        // Sweep filter x edge select x transition direction.
        for (int f = 0; f < 2; f++)
            for (int s = 0; s < 2; s++)
                for (int d = 0; d < 2; d++)
                    one_edge(f[0], s[0], d[0]);

        // Pulse widths around the filter threshold, filter on and off.
        for (int f = 0; f < 2; f++)
            for (int w = 1; w <= 4; w++)
                pulse(f[0], w);

        // R5: interrupt gating.
        filt_en = 1'b0; edge_rise = 1'b1;
        settle(1'b0);
        pin_in = 1'b1;
        wait_neg(6);
        irq_en = 1'b0;
        #1 check(cap_flag == 1'b1 && irq == 1'b0, "R5 irq masked", irq, 0);
        irq_en = 1'b1;
        #1 check(irq == 1'b1, "R5 irq enabled", irq, 1);
        // R7: clear without competing capture.
        wait_neg(1);
        clear_flag();
        check(cap_flag == 1'b0 && irq == 1'b0, "R7 flag cleared", cap_flag, 0);

        // R8: clear strobe on the same edge as a capture.
        settle(1'b0);
        pin_in = 1'b1;
        #1 c0 = count_val;
        wait_neg(3);
        flag_clr = 1'b1;
        wait_neg(1);
        flag_clr = 1'b0;
        check(cap_flag == 1'b1, "R8 capture beats clear flag", cap_flag, 1);
        check(cap_value == c0 + 16'd3, "R8 capture beats clear stamp", cap_value, c0 + 16'd3);

        // R6: blocked capture.
        settle(1'b0);
        cap_block = 1'b1;
        pin_in = 1'b1;
        wait_neg(10);
        check(cap_flag == 1'b0, "R6 blocked flag", cap_flag, 0);
        check(cap_value == exp_val, "R6 blocked value", cap_value, exp_val);

        // R9: write while blocked lands, write while open is ignored.
        wr_data = 16'hBEEF; wr_en = 1'b1;
        wait_neg(1);
        wr_en = 1'b0;
        check(cap_value == 16'hBEEF, "R9 write while blocked", cap_value, 16'hBEEF);
        cap_block = 1'b0;
        wr_data = 16'h1234; wr_en = 1'b1;
        wait_neg(1);
        wr_en = 1'b0;
        wait_neg(1);
        check(cap_value == 16'hBEEF, "R9 write while open ignored", cap_value, 16'hBEEF);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule